// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A starting address is captured from the address bus whenever either of two load strobes is high at a rising clock edge. The two lowest address bits then step through a four-beat burst, moving one beat on each edge where the advance input is high. The upper address bits stay fixed until the next load.

The stepping order is chosen when the burst is loaded. With the order input low (its reset value, matching an unconnected pin), the low bits follow an exclusive-or pattern: beat n equals the start bits XOR n. With the order input high, the low bits count up modulo four from the start value. A load may arrive on any cycle. It ends the burst in progress at once and restarts the sequence from the new address.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, and after it is released with no load yet seen, `addr_out` is all zeros and `valid` is 0.
- R2: A rising edge with `strobe_a` or `strobe_b` high loads `addr_in`. From the next cycle `addr_out` equals that address and `valid` is 1. `valid` stays 1 from then on until reset.
- R3: Having both strobes high in one cycle acts exactly like a single load.
- R4: Outside a load cycle, an edge with `adv` high moves the burst one beat. An edge with `adv` low leaves `addr_out` unchanged.
- R5: With `order_lin` = 0 at the load, beat n has low bits = start low bits XOR n (start 01 gives 01, 00, 11, 10).
- R6: With `order_lin` = 1 at the load, beat n has low bits = (start low bits + n) mod 4 (start 01 gives 01, 10, 11, 00).
- R7: After four advances the low bits return to the start value, and the sequence repeats.
- R8: A load during a burst aborts it and restarts at beat 0 of the new address. `adv` has no effect in a load cycle.
- R9: The upper address bits (all bits above bit 1) do not change between loads.
- R10: The order is sampled only at the load. Changing `order_lin` during a burst does not change the sequence.
- R11: `adv` pulses before the first load have no effect. `addr_out` stays zero and `valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_a | input | 1 | First address load strobe |
| strobe_b | input | 1 | Second address load strobe |
| adv | input | 1 | Advance the burst by one beat |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order; sampled at load |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current burst word address |
| valid | output | 1 | A burst address has been loaded since reset |

## Verification
The bench builds the block with a 10-bit address and the default 2-bit burst counter. This keeps the upper field small, so random loads often reuse or collide with upper values, and any upper-field disturbance shows directly. With the 2-bit counter, every start value and both orders are reached many times. Wraps, back-to-back loads and mid-burst order changes also occur often under random strobes, next to the directed sequences for start 01.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              adv,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              valid
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic              lin_q;
  logic              valid_q;
  logic [CNT_W-1:0]  low;

  wire load = strobe_a | strobe_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      lin_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (load) begin
      base_q  <= addr_in;
      beat_q  <= '0;
      lin_q   <= order_lin;
      valid_q <= 1'b1;
    end else if (adv && valid_q) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign low      = lin_q ? base_q[CNT_W-1:0] + beat_q : base_q[CNT_W-1:0] ^ beat_q;
  assign addr_out = {base_q[ADDR_W-1:CNT_W], low};
  assign valid    = valid_q;

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = base_q[ADDR_W-1:CNT_W];
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_a,
  input logic              strobe_b,
  input logic              adv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              valid,
  input logic              lin_q
);
  logic             ld;
  logic [CNT_W-1:0] nxt_lin;
  assign ld      = strobe_a | strobe_b;
  assign nxt_lin = addr_out[CNT_W-1:0] + 1'b1;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (addr_out == $past(addr_in)) && valid);

  // R2
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv) |=> $stable(addr_out));

  // R6
  lin_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && adv && valid && lin_q) |=> addr_out[CNT_W-1:0] == $past(nxt_lin));

  // R11
  no_load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid && !ld) |=> (!valid && addr_out == '0));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b), .adv(adv),
  .addr_in(addr_in), .addr_out(addr_out), .valid(valid), .lin_q(lin_q)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic sa = 0, sb = 0, av = 0, ln = 0;
  logic [AW-1:0] ain = '0;
  logic [AW-1:0] aout;
  logic vld;

  int checks = 0, fails = 0;
  logic [AW-1:0] m_base = '0;
  int m_beat = 0;
  logic m_lin = 0, m_valid = 0;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) u0 (
    .clk(clk), .rst(rst), .strobe_a(sa), .strobe_b(sb), .adv(av),
    .order_lin(ln), .addr_in(ain), .addr_out(aout), .valid(vld));

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = m_lin ? 2'(m_base[1:0] + 2'(m_beat)) : (m_base[1:0] ^ 2'(m_beat));
    return m_valid ? {m_base[AW-1:2], lo} : '0;
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] ea, input logic ev);
    checks++;
    if (aout !== ea || vld !== ev) begin
      fails++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b", tag, aout, vld, ea, ev);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic v, input logic l,
                      input logic [AW-1:0] d, input string tag);
    sa = a; sb = b; av = v; ln = l; ain = d;
    @(posedge clk);
    if (a || b) begin
      m_base = d; m_beat = 0; m_lin = l; m_valid = 1;
    end else if (v && m_valid) m_beat = (m_beat + 1) % 4;
    @(negedge clk);
    check(tag, exp_addr(), m_valid);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: addr=%h valid=%b expected run to finish", aout, vld);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, 1'b0);
    rst = 0;
    step(0, 0, 1, 1, 10'h3ff, "R11 adv before load");
    step(0, 0, 1, 0, 10'h155, "R11 adv before load");
    check("R1 after reset", '0, 1'b0);

    // R5 interleaved from start 01
    step(1, 0, 0, 0, 10'h2a5, "R2 strobe_a load");
    check("R5 beat0", 10'h2a5, 1);
    step(0, 0, 1, 1, 10'h000, "R5 beat1");
    check("R5 beat1", 10'h2a4, 1);
    step(0, 0, 1, 1, 10'h000, "R10 order change ignored");
    check("R5 beat2", 10'h2a7, 1);
    step(0, 0, 1, 0, 10'h000, "R5 beat3");
    check("R5 beat3", 10'h2a6, 1);
    step(0, 0, 1, 0, 10'h000, "R7 wrap");
    check("R7 wrap interleaved", 10'h2a5, 1);
    step(0, 0, 0, 0, 10'h0ff, "R4 hold");
    check("R4 hold", 10'h2a5, 1);

    // R6 linear from start 01
    step(0, 1, 1, 1, 10'h1c1, "R8 strobe_b load, adv ignored");
    check("R6 beat0", 10'h1c1, 1);
    step(0, 0, 1, 0, 10'h000, "R6 beat1");
    check("R6 beat1", 10'h1c2, 1);
    step(0, 0, 1, 0, 10'h000, "R6 beat2");
    check("R6 beat2", 10'h1c3, 1);
    step(0, 0, 1, 0, 10'h000, "R6 beat3");
    check("R6 beat3", 10'h1c0, 1);
    step(0, 0, 1, 0, 10'h000, "R7 wrap");
    check("R7 wrap linear", 10'h1c1, 1);
    step(0, 0, 1, 0, 10'h000, "R9 upper fixed");
    step(1, 1, 1, 0, 10'h30e, "R3 both strobes");
    check("R3 both strobes", 10'h30e, 1);
    step(0, 0, 1, 0, 10'h000, "R8 restart beat1");
    check("R8 restart", 10'h30f, 1);
    step(1, 0, 0, 1, 10'h30e, "R8 abort mid-burst");
    check("R8 abort", 10'h30e, 1);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 12, (r >= 8 && r < 20), $urandom_range(0, 2) != 0, 1'($urandom),
           AW'($urandom), "R4/R5/R6/R9 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule